// File: doc/BRIEF.md
# Serial memory page-write programming controller

This block sits behind the command decoder of a serial-interface nonvolatile memory. It collects the data bytes of an array write command into a page buffer, keeps the upper address bits fixed, and advances only the in-page offset, so a long burst wraps around inside the page. A status-register write command uses the same path. It captures one byte and later commits only the nonvolatile bits of that byte.

Programming is armed only when chip select rises exactly on a byte boundary, with the write-enable latch set and the protection check passing. Chip select rising at any other point, or under any other condition, drops the command and changes nothing. Once armed, the block raises busy and waits a parameterised number of system clocks that stands in for the self-timed cell programming. It then walks the page and writes only the offsets that actually received a byte. In its last busy cycle it pulses a request that clears the write-enable latch. While busy, every new command, byte and chip-select event is ignored.

Top module: `pw_ctrl`

## Requirements
- R1: A command start captures the upper address bits as the page base and the low 5 bits as the starting offset. Each accepted byte goes to the current offset, and only the offset (the low 5 bits) then advances. Every commit address equals the page base followed by the offset.
- R2: Bytes beyond 32 wrap the offset within the page. A later byte at the same offset replaces the earlier one, and the commit carries the last byte received at each offset.
- R3: Programming arms only on a `cs_rise` pulse with `cs_at_boundary`=1. A `cs_rise` with `cs_at_boundary`=0 aborts the command: busy stays low and nothing is committed.
- R4: If `wen_latch`=0 when `cs_rise` arrives, the command is dropped: no busy, no commit, no `wel_clr`.
- R5: If `prot_ok`=0 when `cs_rise` arrives, the command is dropped: no busy, no commit.
- R6: Busy rises in the cycle after the arming `cs_rise` is sampled. For an array write it stays high for exactly PROG_CYCLES+32+1 cycles, and for a status write for exactly PROG_CYCLES+1 cycles.
- R7: The commit writes each offset that received a byte exactly once, and writes no offset that received none.
- R8: `wel_clr` pulses for one cycle, in the last busy cycle of every armed command, and never otherwise.
- R9: A status write (`cmd_is_status`=1) commits its first received byte once through `sr_we`, with every bit outside the nonvolatile mask 8'h8C (bits 7, 3 and 2) forced to 0. It produces no array writes.
- R10: While busy, `cmd_start`, `byte_vld` and `cs_rise` have no effect. No extra commit follows, and the busy length is unchanged.
- R11: After reset, `busy`, `wel_clr`, `mem_we` and `sr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse: a write command has been decoded |
| cmd_is_status | input | 1 | 1 = status-register write, 0 = array write |
| cmd_addr | input | ADDR_W | Start address of the array write |
| byte_vld | input | 1 | One-cycle pulse: a data byte is complete |
| byte_data | input | 8 | The completed data byte |
| cs_rise | input | 1 | One-cycle pulse: chip select went inactive |
| cs_at_boundary | input | 1 | The chip-select rise fell exactly after a whole byte |
| wen_latch | input | 1 | Current state of the write-enable latch |
| prot_ok | input | 1 | Protection checks allow this write |
| busy | output | 1 | Internal write cycle in progress |
| wel_clr | output | 1 | Pulse that clears the write-enable latch at completion |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| sr_we | output | 1 | Status nonvolatile-bit write strobe |
| sr_wdata | output | 8 | Status write data, masked to the nonvolatile bits |

## Verification
The assertions assume the following about the inputs. `cmd_start`, `byte_vld` and `cs_rise` are single-cycle pulses, never two in the same cycle. `cmd_start` comes only between chip-select rises. The qualifiers `cs_at_boundary`, `wen_latch` and `prot_ok` are valid whenever `cs_rise` is high. The stimulus drives each event for one clock with an idle clock after it, and sets the qualifiers in the same cycle as the chip-select rise. It also issues commands during busy to show that they are dropped.

// File: rtl/pw_pkg.sv
// Shared types for the page-write controller.
package pw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RECV   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_COMMIT = 3'd3,
        ST_DONE   = 3'd4
    } pw_state_e;
endpackage

// File: rtl/pw_page_buf.sv
// Page buffer: holds one page of received bytes plus a per-offset valid mask.
// A clear loads the starting offset and empties the mask. Each write stores
// at the offset pointer and advances it by one, wrapping inside the page.
// Assumes PAGE_BYTES is a power of two so the pointer wraps naturally.
module pw_page_buf #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    parameter int OFS_W      = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [OFS_W-1:0]  start_ofs,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              any_vld
);
    logic [PAGE_BYTES-1:0] vmask;
    logic [OFS_W-1:0]      ptr;
    logic [DATA_W-1:0]     slots [PAGE_BYTES];

    // Pointer and valid mask: loaded by clear, advanced by each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmask <= '0;
            ptr   <= '0;
        end else if (clr) begin
            vmask <= '0;
            ptr   <= start_ofs;
        end else if (wr_en) begin
            vmask[ptr] <= 1'b1;
            ptr        <= ptr + OFS_W'(1);
        end
    end

    // Data storage: no reset needed, the mask qualifies every slot.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            slots[ptr] <= wr_data;
        end
    end

    // Read port used by the commit walk.
    always_comb begin
        rd_data = slots[rd_idx];
        rd_vld  = vmask[rd_idx];
        any_vld = |vmask;
    end

    AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> vmask[$past(ptr)]); // R7
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vmask == '0)); // R7
endmodule

// File: rtl/pw_cycle_timer.sv
// Programming delay timer: after a start pulse it runs for exactly LIMIT
// cycles and flags done in the last one. Assumes LIMIT >= 1.
module pw_cycle_timer #(
    parameter int LIMIT = 40,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    logic             run;
    logic [CNT_W-1:0] cnt;

    // Counter: cleared on start, counts while running, stops at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (run) begin
            if (cnt == CNT_W'(LIMIT - 1)) begin
                run <= 1'b0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Done flag in the final counted cycle.
    always_comb begin
        done = run && (cnt == CNT_W'(LIMIT - 1));
    end

    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CNT_W'(LIMIT))); // R6
    AST_TMR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !run); // R6
endmodule

// File: rtl/pw_ctrl.sv
// Page-write and self-timed programming controller.
// Collects write data into a page buffer, arms on a legal chip-select rise,
// waits PROG_CYCLES clocks, then commits the received offsets to the array
// (or the masked byte to the status register) and requests a latch clear.
// Assumes single-cycle, mutually exclusive event pulses on the inputs, and
// a power-of-two PAGE_BYTES.
module pw_ctrl #(
    parameter int          ADDR_W      = 12,
    parameter int          PAGE_BYTES  = 32,
    parameter int          PROG_CYCLES = 40,
    parameter logic [7:0]  SR_NV_MASK  = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_is_status,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              cs_rise,
    input  logic              cs_at_boundary,
    input  logic              wen_latch,
    input  logic              prot_ok,
    output logic              busy,
    output logic              wel_clr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              sr_we,
    output logic [7:0]        sr_wdata
);
    import pw_pkg::*;

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFS_W;

    pw_state_e         state;
    logic [BASE_W-1:0] base;
    logic              is_sr;
    logic [7:0]        sr_hold;
    logic              sr_got;
    logic [OFS_W-1:0]  walk;
    logic              buf_clr;
    logic              buf_wr;
    logic [7:0]        rd_data;
    logic              rd_vld;
    logic              any_vld;
    logic              tmr_start;
    logic              tmr_done;
    logic              arm_ok;

    // Buffer control and arming decision.
    always_comb begin
        buf_clr   = (state == ST_IDLE) && cmd_start;
        buf_wr    = (state == ST_RECV) && byte_vld && !is_sr;
        arm_ok    = cs_at_boundary && wen_latch && prot_ok &&
                    (is_sr ? sr_got : any_vld);
        tmr_start = (state == ST_RECV) && cs_rise && arm_ok;
    end

    pw_page_buf #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (8),
        .OFS_W      (OFS_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .start_ofs (cmd_addr[OFS_W-1:0]),
        .wr_en     (buf_wr),
        .wr_data   (byte_data),
        .rd_idx    (walk),
        .rd_data   (rd_data),
        .rd_vld    (rd_vld),
        .any_vld   (any_vld)
    );

    pw_cycle_timer #(
        .LIMIT (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .done  (tmr_done)
    );

    // Command sequencer: receive, arm, wait, commit, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            walk  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cmd_start) state <= ST_RECV;
                end
                ST_RECV: begin
                    if (cs_rise) state <= arm_ok ? ST_WAIT : ST_IDLE;
                end
                ST_WAIT: begin
                    if (tmr_done) begin
                        state <= is_sr ? ST_DONE : ST_COMMIT;
                        walk  <= '0;
                    end
                end
                ST_COMMIT: begin
                    if (walk == OFS_W'(PAGE_BYTES - 1)) state <= ST_DONE;
                    walk <= walk + OFS_W'(1);
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Command context: page base, command kind and the status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base    <= '0;
            is_sr   <= 1'b0;
            sr_hold <= '0;
            sr_got  <= 1'b0;
        end else if (buf_clr) begin
            base    <= cmd_addr[ADDR_W-1:OFS_W];
            is_sr   <= cmd_is_status;
            sr_got  <= 1'b0;
        end else if ((state == ST_RECV) && byte_vld && is_sr && !sr_got) begin
            sr_hold <= byte_data;
            sr_got  <= 1'b1;
        end
    end

    // Output decode from state registers only.
    always_comb begin
        busy      = (state == ST_WAIT) || (state == ST_COMMIT) || (state == ST_DONE);
        wel_clr   = (state == ST_DONE);
        mem_we    = (state == ST_COMMIT) && rd_vld;
        mem_addr  = {base, walk};
        mem_wdata = rd_data;
        sr_we     = (state == ST_DONE) && is_sr;
        sr_wdata  = sr_hold & SR_NV_MASK;
    end

    AST_ARM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise && cs_at_boundary && wen_latch && prot_ok)); // R3
    AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || sr_we) |-> busy); // R7
    AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFS_W] == $past(mem_addr[ADDR_W-1:OFS_W]))); // R1
    AST_CLR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !busy); // R8
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !wel_clr) |=> busy); // R10
    AST_SR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        sr_we |-> ((sr_wdata & ~SR_NV_MASK) == 8'h00)); // R9
    AST_NO_FILL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr); // R10
endmodule

// File: tb/sim_pw_ctrl.sv
module sim_pw_ctrl;
    localparam int AW   = 12;
    localparam int PC   = 40;
    localparam int ARR_BUSY = PC + 32 + 1;
    localparam int SR_BUSY  = PC + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic          cmd_is_status = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_vld = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          cs_at_boundary = 1'b0;
    logic          wen_latch = 1'b0;
    logic          prot_ok = 1'b0;
    logic          busy, wel_clr, mem_we, sr_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata, sr_wdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] shadow [4096];
    int         wcount [4096];
    int wr_cnt = 0, busy_cnt = 0, wel_cnt = 0, sr_cnt = 0;
    logic [7:0] sr_last = '0;

    always #4 clk = ~clk;

    pw_ctrl #(.ADDR_W(AW), .PAGE_BYTES(32), .PROG_CYCLES(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_is_status(cmd_is_status),
        .cmd_addr(cmd_addr), .byte_vld(byte_vld), .byte_data(byte_data),
        .cs_rise(cs_rise), .cs_at_boundary(cs_at_boundary), .wen_latch(wen_latch),
        .prot_ok(prot_ok), .busy(busy), .wel_clr(wel_clr), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sr_we(sr_we), .sr_wdata(sr_wdata)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                shadow[mem_addr] <= mem_wdata;
                wcount[mem_addr] <= wcount[mem_addr] + 1;
                wr_cnt <= wr_cnt + 1;
            end
            if (busy)    busy_cnt <= busy_cnt + 1;
            if (wel_clr) wel_cnt  <= wel_cnt + 1;
            if (sr_we) begin
                sr_cnt  <= sr_cnt + 1;
                sr_last <= sr_wdata;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d", req, got, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        for (int a = 0; a < 4096; a++) wcount[a] = 0;
        wr_cnt = 0; busy_cnt = 0; wel_cnt = 0; sr_cnt = 0;
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    task automatic send_cmd(input bit is_sr, input logic [AW-1:0] addr, input int n,
                            input logic [7:0] seed, input bit bnd, input bit wen, input bit prot);
        @(negedge clk);
        cmd_start = 1'b1; cmd_is_status = is_sr; cmd_addr = addr;
        @(negedge clk);
        cmd_start = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = pat(seed, i);
            @(negedge clk);
            byte_vld = 1'b0;
            @(negedge clk);
        end
        cs_rise = 1'b1; cs_at_boundary = bnd; wen_latch = wen; prot_ok = prot;
        @(negedge clk);
        cs_rise = 1'b0; cs_at_boundary = 1'b0;
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0 && wel_clr == 0 && mem_we == 0 && sr_we == 0, "R11 reset outputs",
            int'({busy, wel_clr, mem_we, sr_we}), 0);
    endtask

    task automatic t_basic();
        clear_log();
        send_cmd(1'b0, 12'h123, 3, 8'h10, 1'b1, 1'b1, 1'b1);
        settle();
        chk(wr_cnt == 3, "R7 three writes", wr_cnt, 3);
        chk(shadow[12'h123] == pat(8'h10, 0) && shadow[12'h124] == pat(8'h10, 1) &&
            shadow[12'h125] == pat(8'h10, 2), "R1 addresses and data",
            int'(shadow[12'h125]), int'(pat(8'h10, 2)));
        chk(wcount[12'h122] == 0 && wcount[12'h126] == 0, "R7 untouched offsets",
            wcount[12'h122] + wcount[12'h126], 0);
        chk(busy_cnt == ARR_BUSY, "R6 array busy length", busy_cnt, ARR_BUSY);
        chk(wel_cnt == 1, "R8 latch clear pulse", wel_cnt, 1);
    endtask

    task automatic t_wrap();
        logic [7:0] exp [32];
        int mism;
        clear_log();
        for (int i = 0; i < 35; i++) exp[(30 + i) % 32] = pat(8'h55, i);
        send_cmd(1'b0, 12'h45E, 35, 8'h55, 1'b1, 1'b1, 1'b1);
        settle();
        mism = 0;
        for (int o = 0; o < 32; o++) begin
            if (shadow[12'h440 + o] != exp[o] || wcount[12'h440 + o] != 1) mism++;
        end
        chk(mism == 0, "R2 wrapped page contents", mism, 0);
        chk(wr_cnt == 32, "R7 each offset once", wr_cnt, 32);
        chk(wcount[12'h460] == 0 && wcount[12'h43F] == 0, "R1 upper bits fixed",
            wcount[12'h460] + wcount[12'h43F], 0);
    endtask

    task automatic t_reject(input bit bnd, input bit wen, input bit prot, input string req);
        clear_log();
        send_cmd(1'b0, 12'h300, 2, 8'hA0, bnd, wen, prot);
        settle();
        chk(busy_cnt == 0 && wr_cnt == 0 && wel_cnt == 0, req, busy_cnt + wr_cnt + wel_cnt, 0);
    endtask

    task automatic t_status();
        clear_log();
        send_cmd(1'b1, 12'h000, 2, 8'hFF, 1'b1, 1'b1, 1'b1);
        settle();
        chk(sr_cnt == 1 && sr_last == 8'h8C, "R9 masked status commit", int'(sr_last), 8'h8C);
        chk(wr_cnt == 0, "R9 no array writes", wr_cnt, 0);
        chk(busy_cnt == SR_BUSY, "R6 status busy length", busy_cnt, SR_BUSY);
        chk(wel_cnt == 1, "R8 latch clear after status", wel_cnt, 1);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        send_cmd(1'b0, 12'h200, 2, 8'h33, 1'b1, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        send_cmd(1'b0, 12'h3A0, 3, 8'h77, 1'b1, 1'b1, 1'b1);
        settle();
        chk(wr_cnt == 2 && wcount[12'h3A0] == 0, "R10 command during busy dropped", wr_cnt, 2);
        chk(busy_cnt == ARR_BUSY, "R10 busy not extended", busy_cnt, ARR_BUSY);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) shadow[a] = 8'h00;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_wrap();
        t_reject(1'b0, 1'b1, 1'b1, "R3 off-boundary abort");
        t_reject(1'b1, 1'b0, 1'b1, "R4 latch clear ignored");
        t_reject(1'b1, 1'b1, 1'b0, "R5 protected ignored");
        t_status();
        t_busy_ignore();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule